// File: doc/BRIEF.md
# Bit Test and First-One Scan Unit

This unit performs single-bit operations on a 16-bit word, one request per cycle. A request carries the word, a bit position and an operation code. The test operations return the addressed bit on a carry output. They also return a copy of the word with that bit kept, forced to one, forced to zero or inverted. The scan operations search the word for its first one bit, either from bit 0 upward or from the top bit downward. They return that bit's position and raise a zero-style status flag when a one was found.

Each request is taken on a clock edge while the strobe is high. The outputs change at that edge and hold until the next accepted request, so a processor datapath can read them as architectural state. A done pulse marks the cycle in which the new values are visible. The carry and status flags belong to separate operation groups, so each group leaves the other group's flag untouched.

Top module: `bitop_unit`

## Requirements
- R1: While reset is asserted (rst_n low), result, carry, zero flag and done all read 0.
- R2: done is high for exactly the one cycle after each clock edge at which valid was high, and low after an edge with valid low.
- R3: For op codes 0 to 3, carry takes the value the addressed operand bit had before any change is made to it.
- R4: Op code 0 (test) returns the operand unchanged in the result.
- R5: Op codes 1, 2 and 3 return the operand with the addressed bit set to 1, cleared to 0, or inverted, respectively. All other bits are unchanged.
- R6: Op code 4 (upward scan) with a nonzero operand returns the position of the lowest one bit, zero-extended into the result.
- R7: Op code 5 (downward scan) with a nonzero operand returns the position of the highest one bit, zero-extended into the result.
- R8: A scan sets the zero flag to 1 when the operand is nonzero. A scan of an all-zero operand sets the zero flag to 0 and leaves the result at its previous value.
- R9: Carry is changed only by op codes 0 to 3, and the zero flag only by op codes 4 and 5.
- R10: Op codes 6 and 7 change neither result, carry nor zero flag; done still pulses.
- R11: When valid is low, result, carry and zero flag hold their values.
- R12: The bit position input is 4 bits wide and covers every bit 0 to 15 directly, so it is taken modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code (0 test, 1 set, 2 clear, 3 invert, 4 scan up, 5 scan down, 6-7 none) |
| operand_i | input | 16 | Source word |
| bit_idx_i | input | 4 | Addressed bit position for op codes 0 to 3 |
| result_o | output | 16 | Modified word or scan position |
| carry_o | output | 1 | Addressed bit before modification |
| zero_o | output | 1 | Scan status, 1 when a one bit was found |
| done_o | output | 1 | One-cycle pulse when new values are visible |

## Verification
Two things happen in the same edge for a modifying test: the addressed bit is captured into carry and rewritten in the result. The bench drives set, clear and invert requests at bits whose original value is both 0 and 1, at positions 0 and 15. A correct carry then shows the pre-change value while the result shows the post-change value. The other collision is between a scan of an all-zero word and the held result. Zero-word scans are placed straight after requests that leave a nonzero result, and in long back-to-back random runs. The bench checks that the flag drops while the result keeps the earlier value. Every cycle is compared against a behavioural model.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [2:0] {
        OP_TEST    = 3'd0,
        OP_SET     = 3'd1,
        OP_CLEAR   = 3'd2,
        OP_FLIP    = 3'd3,
        OP_SCAN_LO = 3'd4,
        OP_SCAN_HI = 3'd5,
        OP_NONE_A  = 3'd6,
        OP_NONE_B  = 3'd7
    } bitop_e;

    // The test group occupies codes 0..3, so the low two bits select the action.
    function automatic logic is_test_op(input bitop_e op);
        return (op == OP_TEST) || (op == OP_SET) || (op == OP_CLEAR) || (op == OP_FLIP);
    endfunction

    function automatic logic is_scan_op(input bitop_e op);
        return (op == OP_SCAN_LO) || (op == OP_SCAN_HI);
    endfunction

endpackage

// File: rtl/bitop_modify.sv
module bitop_modify #(
    parameter int WIDTH = 16,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] word_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [1:0]       action_i,
    output logic [WIDTH-1:0] word_o,
    output logic             picked_o
);

    logic [WIDTH-1:0] mask;

    always_comb begin
        mask     = WIDTH'(1) << idx_i;
        picked_o = word_i[idx_i];
        unique case (action_i)
            2'd0:    word_o = word_i;
            2'd1:    word_o = word_i | mask;
            2'd2:    word_o = word_i & ~mask;
            default: word_o = word_i ^ mask;
        endcase
    end

endmodule

// File: rtl/bitop_scan.sv
module bitop_scan #(
    parameter int WIDTH    = 16,
    parameter int IDX_W    = $clog2(WIDTH),
    parameter bit FROM_MSB = 1'b0
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    assign found_o = |vec_i;

    generate
        if (FROM_MSB) begin : g_from_top
            // Ascending walk: the last one seen is the highest.
            always_comb begin
                idx_o = '0;
                for (int i = 0; i < WIDTH; i++) begin
                    if (vec_i[i]) idx_o = IDX_W'(i);
                end
            end
        end else begin : g_from_bottom
            // Descending walk: the last one seen is the lowest.
            always_comb begin
                idx_o = '0;
                for (int i = WIDTH - 1; i >= 0; i--) begin
                    if (vec_i[i]) idx_o = IDX_W'(i);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit #(
    parameter int WIDTH = 16,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] operand_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             zero_o,
    output logic             done_o
);
    import bitop_pkg::*;

    localparam int PAD_W = WIDTH - IDX_W;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             carry;
        logic             zero;
        logic             done;
    } state_t;

    state_t state_d, state_q;

    bitop_e           op_sel;
    logic [WIDTH-1:0] mod_word;
    logic             mod_bit;
    logic             lo_found, hi_found;
    logic [IDX_W-1:0] lo_idx, hi_idx;

    assign op_sel = bitop_e'(op_i);

    bitop_modify #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_modify (
        .word_i   (operand_i),
        .idx_i    (bit_idx_i),
        .action_i (op_i[1:0]),
        .word_o   (mod_word),
        .picked_o (mod_bit)
    );

    bitop_scan #(.WIDTH(WIDTH), .IDX_W(IDX_W), .FROM_MSB(1'b0)) u_scan_lo (
        .vec_i   (operand_i),
        .found_o (lo_found),
        .idx_o   (lo_idx)
    );

    bitop_scan #(.WIDTH(WIDTH), .IDX_W(IDX_W), .FROM_MSB(1'b1)) u_scan_hi (
        .vec_i   (operand_i),
        .found_o (hi_found),
        .idx_o   (hi_idx)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = valid_i;
        if (valid_i) begin
            if (is_test_op(op_sel)) begin
                state_d.result = mod_word;
                state_d.carry  = mod_bit;
            end else if (op_sel == OP_SCAN_LO) begin
                state_d.zero = lo_found;
                if (lo_found) state_d.result = {{PAD_W{1'b0}}, lo_idx};
            end else if (op_sel == OP_SCAN_HI) begin
                state_d.zero = hi_found;
                if (hi_found) state_d.result = {{PAD_W{1'b0}}, hi_idx};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result_o = state_q.result;
    assign carry_o  = state_q.carry;
    assign zero_o   = state_q.zero;
    assign done_o   = state_q.done;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int WIDTH = 16,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] operand_i,
    input logic [IDX_W-1:0] bit_idx_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             zero_o,
    input logic             done_o
);

    logic [2:0]       seen_op;
    logic [WIDTH-1:0] seen_word;
    logic [IDX_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_op   <= 3'd6;
            seen_word <= '0;
        end else if (valid_i) begin
            seen_op   <= op_i;
            seen_word <= operand_i;
        end
    end

    assign pos = result_o[IDX_W-1:0];

    p_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !done_o);
    p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i < 3'd4) |=> carry_o == $past(operand_i[bit_idx_i]));
    p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd0) |=> result_o == $past(operand_i));
    p_others_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i != 3'd0 && op_i < 3'd4) |=>
            $countones(result_o ^ $past(operand_i)) <= 1);
    p_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && seen_op == 3'd4 && seen_word != '0) |->
            (seen_word[pos] && (seen_word & ((WIDTH'(1) << pos) - WIDTH'(1))) == '0
             && result_o[WIDTH-1:IDX_W] == '0));
    p_highest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && seen_op == 3'd5 && seen_word != '0) |->
            ((seen_word >> pos) == WIDTH'(1) && result_o[WIDTH-1:IDX_W] == '0));
    p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == 3'd4 || op_i == 3'd5)) |=> zero_o == ($past(operand_i) != '0));
    p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == 3'd4 || op_i == 3'd5) && operand_i == '0) |=> $stable(result_o));
    p_carry_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i >= 3'd4) |=> $stable(carry_o));
    p_zero_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i < 3'd4) |=> $stable(zero_o));
    p_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i >= 3'd6) |=> ($stable(result_o) && $stable(carry_o) && $stable(zero_o)));
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(result_o) && $stable(carry_o) && $stable(zero_o)));

endmodule

bind bitop_unit bitop_unit_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .operand_i (operand_i),
    .bit_idx_i (bit_idx_i),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .zero_o    (zero_o),
    .done_o    (done_o)
);

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] opnd = 16'h0;
    logic [3:0]  idx = 4'd0;
    logic [15:0] result;
    logic        carry, zero, done;

    int n_cmp = 0;
    int n_bad = 0;

    bitop_unit u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid), .op_i(op), .operand_i(opnd),
        .bit_idx_i(idx), .result_o(result), .carry_o(carry), .zero_o(zero), .done_o(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic [15:0] m_res = 16'h0;
    logic        m_c = 1'b0, m_z = 1'b0, m_d = 1'b0;
    string       t_res = "R1", t_c = "R1", t_z = "R1", t_d = "R1";
    bit          started = 1'b0;

    always @(posedge clk) begin : model
        int pos;
        started <= 1'b1;
        if (!rst_n) begin
            m_res <= 16'h0; m_c <= 1'b0; m_z <= 1'b0; m_d <= 1'b0;
            t_res <= "R1"; t_c <= "R1"; t_z <= "R1"; t_d <= "R1";
        end else begin
            m_d <= valid;
            t_d <= "R2";
            if (!valid) begin
                t_res <= "R11"; t_c <= "R11"; t_z <= "R11";
            end else if (op <= 3'd3) begin
                m_c <= opnd[idx];
                t_c <= "R3"; t_z <= "R9";
                case (op)
                    3'd0: begin m_res <= opnd; t_res <= "R4"; end
                    3'd1: begin m_res <= opnd | (16'h1 << idx); t_res <= "R5"; end
                    3'd2: begin m_res <= opnd & ~(16'h1 << idx); t_res <= "R5"; end
                    default: begin m_res <= opnd ^ (16'h1 << idx); t_res <= "R5"; end
                endcase
            end else if (op <= 3'd5) begin
                t_c <= "R9"; t_z <= "R8";
                if (opnd == 16'h0) begin
                    m_z <= 1'b0; t_res <= "R8";
                end else begin
                    pos = -1;
                    for (int k = 0; k < 16; k++) begin
                        if (opnd[k] && (op == 3'd5 || pos < 0)) pos = k;
                    end
                    m_res <= 16'(pos); m_z <= 1'b1;
                    t_res <= (op == 3'd4) ? "R6" : "R7";
                end
            end else begin
                t_res <= "R10"; t_c <= "R10"; t_z <= "R10";
            end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check(t_res, "result", int'(result), int'(m_res));
            check(t_c,   "carry",  int'(carry),  int'(m_c));
            check(t_z,   "zero",   int'(zero),   int'(m_z));
            check(t_d,   "done",   int'(done),   int'(m_d));
        end
    end

    task automatic issue(input logic [2:0] o, input logic [15:0] w, input logic [3:0] b);
        @(negedge clk);
        valid = 1'b1; op = o; opnd = w; idx = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid = 1'b0; op = 3'($urandom); opnd = 16'($urandom); idx = 4'($urandom);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);           // R1 reset values compared
        rst_n = 1'b1;
        idle(2);                             // R11 hold after reset
        issue(3'd0, 16'hA5A5, 4'd0);         // R3 carry 1, R4
        issue(3'd0, 16'hA5A5, 4'd1);         // R3 carry 0
        issue(3'd1, 16'h0000, 4'd15);        // R5 set -> 8000, R12 top index
        issue(3'd2, 16'hFFFF, 4'd0);         // R5 clear -> FFFE, carry 1
        issue(3'd3, 16'h1234, 4'd4);         // R5 invert -> 1224, carry 1
        issue(3'd3, 16'h1224, 4'd4);         // R5 invert back, carry 0
        issue(3'd4, 16'h0000, 4'd0);         // R8 empty scan keeps 1234
        issue(3'd4, 16'h8000, 4'd0);         // R6 -> 15
        issue(3'd5, 16'h0001, 4'd0);         // R7 -> 0
        issue(3'd5, 16'h0000, 4'd0);         // R8 hold 0
        issue(3'd5, 16'hFFFF, 4'd0);         // R7 -> 15
        issue(3'd4, 16'hFFFF, 4'd0);         // R6 -> 0
        issue(3'd4, 16'h0060, 4'd0);         // R6 -> 5
        issue(3'd5, 16'h0060, 4'd0);         // R7 -> 6
        issue(3'd6, 16'hFFFF, 4'd3);         // R10
        issue(3'd7, 16'h0000, 4'd9);         // R10
        issue(3'd1, 16'h7FFF, 4'd15);        // R9 zero unchanged, R5
        idle(3);
        for (int n = 0; n < 600; n++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if (($urandom % 8) == 0) w = 16'h0;
            if (($urandom % 4) == 0) idle(1);
            else issue(3'($urandom), w, 4'($urandom));
        end
        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule